// File: doc/BRIEF.md
# Zero-Crossing Deglitch Controller

This block sits between the register that holds each new audio sample and the pins that drive a resistor ladder. Samples arrive as offset-binary words (mid-scale, top bit set and all others clear, is the analog zero). Each accepted word is compared with the word accepted before it. When the pair is the major-carry step across zero, the top bit changes while every lower bit moves the opposite way. The ladder glitches worst on this step, so the block raises a timed mute line for a fast external analog switch. The mute starts in the same cycle the new word reaches the outputs.

An optional threshold detector also flags any step that toggles more than a chosen number of bits. An optional output coding replaces the offset-binary word with a sign line and a magnitude word, for hardware that uses two ladders. The mute length is programmable in system clocks. A second flagged step during an active mute starts the count again.

Top module: `zc_deglitch`

## Requirements
- R1: After reset, `dac_word` is mid-scale (only bit WIDTH-1 set), `dac_neg` is 0 and `mute` is 0; the reference word for the first comparison is mid-scale.
- R2: A word presented with `smp_valid` high at a rising edge appears on `dac_word` after that edge and is held until the next accepted word.
- R3: A step is flagged when the previous accepted word is 0111...1 and the new one is 1000...0, or the reverse; `mute` rises in the cycle the new word appears.
- R4: `mute` stays high for exactly N clocks, where N is `mute_len`, or the parameter PULSE_DEFAULT (8) when `mute_len` is 0.
- R5: A flagged step while `mute` is high reloads the count, so the mute lasts N clocks from the new word.
- R6: With the threshold detector off, a step that is not the major carry never raises `mute`; this includes the full-scale step 000...0 to 111...1.
- R7: With `cnt_en` high, a step that toggles more than `cnt_limit` bits is also flagged; a step toggling `cnt_limit` bits or fewer is not.
- R8: With `sm_en` high, `dac_neg` is 1 when the input's top bit is 0 (below zero), `dac_word[WIDTH-1]` is 0, and `dac_word[WIDTH-2:0]` holds the distance from mid-scale.
- R9: In sign-magnitude coding the most negative input 000...0 gives magnitude 0111...1 (saturated), and with `sm_en` low `dac_neg` is 0 and `dac_word` equals the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Accept `smp_word` at this edge |
| smp_word | input | WIDTH | New sample, offset binary |
| mute_len | input | LEN_W | Mute length in clocks, 0 selects PULSE_DEFAULT |
| cnt_en | input | 1 | Enable the bit-count detector |
| cnt_limit | input | CNT_W | Bits-toggled limit for the count detector |
| sm_en | input | 1 | Select sign-magnitude output coding |
| dac_word | output | WIDTH | Word driving the ladder |
| dac_neg | output | 1 | Sign line for dual-ladder hardware |
| mute | output | 1 | Deglitch mute to the analog switch |

## Verification
The carry steps are driven in both directions: up from just below zero, and down from zero. This shows that the detector fires on the exact two-code pair and not on every step with a flipped top bit. The full-scale jump and small steps near zero show the detector is not merely counting toggles when the count detector is off. With the count detector on, steps just above and at the limit pin down the comparison. Back-to-back carries inside a pulse show a reload rather than an extension or early end. Sign-magnitude runs cover both rails, mid-scale, a code just below mid-scale and the saturated most-negative code.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
   // Detector flavours chosen at elaboration
   typedef enum logic [0:0] {
      DET_CARRY_ONLY = 1'b0,
      DET_CARRY_AND_COUNT = 1'b1
   } det_variant_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = $clog2(v);
      return (r == 0) ? 1 : r;
   endfunction
endpackage

// File: rtl/zcd_detect.sv
module zcd_detect
   import zcd_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter det_variant_e VARIANT = DET_CARRY_AND_COUNT,
   localparam int unsigned CNT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] prev_word,
   input  logic [WIDTH-1:0] new_word,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] cnt_limit,
   output logic             hit
);
   logic carry_hit;
   logic count_hit;
   logic [WIDTH-1:0] toggled;

   assign toggled = prev_word ^ new_word;

   // Major carry: lower bits all the inverse of the top bit, and every bit flips
   always_comb begin
      carry_hit = (&toggled) &&
                  (prev_word[WIDTH-2:0] == {(WIDTH-1){~prev_word[WIDTH-1]}});
   end

   generate
      if (VARIANT == DET_CARRY_AND_COUNT) begin : g_count
         logic [CNT_W-1:0] ones;
         always_comb begin
            ones = '0;
            for (int i = 0; i < WIDTH; i++) begin
               ones = ones + CNT_W'(toggled[i]);
            end
         end
         assign count_hit = cnt_en && (ones > cnt_limit);
      end else begin : g_nocount
         logic unused_cfg;
         assign unused_cfg = cnt_en ^ (^cnt_limit);
         assign count_hit = 1'b0;
      end
   endgenerate

   assign hit = carry_hit | count_hit;
endmodule

// File: rtl/zcd_encode.sv
module zcd_encode #(
   parameter int unsigned WIDTH = 16,
   parameter bit          HAS_SM = 1'b1
) (
   input  logic [WIDTH-1:0] in_word,
   input  logic             sm_en,
   output logic [WIDTH-1:0] enc_word,
   output logic             enc_neg
);
   generate
      if (HAS_SM) begin : g_sm
         logic             below;
         logic [WIDTH-2:0] mag;
         assign below = ~in_word[WIDTH-1];
         always_comb begin
            if (!below) begin
               mag = in_word[WIDTH-2:0];
            end else if (in_word == '0) begin
               mag = '1;                        // saturate most-negative code
            end else begin
               mag = (~in_word[WIDTH-2:0]) + 1'b1;  // mid-scale minus input
            end
         end
         always_comb begin
            if (sm_en) begin
               enc_word = {1'b0, mag};
               enc_neg  = below;
            end else begin
               enc_word = in_word;
               enc_neg  = 1'b0;
            end
         end
      end else begin : g_pass
         logic unused_sm;
         assign unused_sm = sm_en;
         assign enc_word = in_word;
         assign enc_neg  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/zcd_pulse.sv
module zcd_pulse #(
   parameter int unsigned LEN_W = 8,
   parameter int unsigned PULSE_DEFAULT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LEN_W-1:0] len,
   output logic             active
);
   localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(PULSE_DEFAULT);

   logic [LEN_W-1:0] remain;
   logic [LEN_W-1:0] load_val;

   assign load_val = (len == '0) ? DEF_LEN : len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (fire) begin
         remain <= load_val;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign active = (remain != '0);
endmodule

// File: rtl/zc_deglitch.sv
module zc_deglitch
   import zcd_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned LEN_W = 8,
   parameter int unsigned PULSE_DEFAULT = 8,
   parameter bit          HAS_COUNT = 1'b1,
   parameter bit          HAS_SM = 1'b1,
   localparam int unsigned CNT_W = $clog2(WIDTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [WIDTH-1:0] smp_word,
   input  logic [LEN_W-1:0] mute_len,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] cnt_limit,
   input  logic             sm_en,
   output logic [WIDTH-1:0] dac_word,
   output logic             dac_neg,
   output logic             mute
);
   localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};
   localparam det_variant_e VAR = HAS_COUNT ? DET_CARRY_AND_COUNT : DET_CARRY_ONLY;

   initial begin
      assert (WIDTH >= 4) else $error("WIDTH must be at least 4");
      assert (PULSE_DEFAULT > 0 && PULSE_DEFAULT < (1 << LEN_W))
         else $error("PULSE_DEFAULT must fit LEN_W and be nonzero");
   end

   logic [WIDTH-1:0] last_word;
   logic             step_hit;
   logic [WIDTH-1:0] enc_word;
   logic             enc_neg;

   zcd_detect #(.WIDTH(WIDTH), .VARIANT(VAR)) u_det (
      .prev_word (last_word),
      .new_word  (smp_word),
      .cnt_en    (cnt_en),
      .cnt_limit (cnt_limit),
      .hit       (step_hit)
   );

   zcd_encode #(.WIDTH(WIDTH), .HAS_SM(HAS_SM)) u_enc (
      .in_word  (smp_word),
      .sm_en    (sm_en),
      .enc_word (enc_word),
      .enc_neg  (enc_neg)
   );

   zcd_pulse #(.LEN_W(LEN_W), .PULSE_DEFAULT(PULSE_DEFAULT)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (smp_valid & step_hit),
      .len    (mute_len),
      .active (mute)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_word <= MID;
         dac_word  <= MID;
         dac_neg   <= 1'b0;
      end else if (smp_valid) begin
         last_word <= smp_word;
         dac_word  <= enc_word;
         dac_neg   <= enc_neg;
      end
   end
endmodule

// File: rtl/zcd_checker.sv
module zcd_checker #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic [WIDTH-1:0] smp_word,
   input logic             sm_en,
   input logic [WIDTH-1:0] dac_word,
   input logic             mute
);
   localparam logic [WIDTH-1:0] MID  = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic [WIDTH-1:0] BELOW = {1'b0, {(WIDTH-1){1'b1}}};

   logic [WIDTH-1:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= MID;
      else if (smp_valid) seen <= smp_word;
   end

   // R2: outputs change only after an accepted sample
   assert_hold_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(dac_word));

   // R3: carry up or down raises mute with the new word
   assert_carry_mutes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ((seen == BELOW && smp_word == MID) ||
                     (seen == MID && smp_word == BELOW))) |=> mute);

   // R6: mute never starts without an accepted sample
   assert_mute_needs_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute) |-> $past(smp_valid));

   // R8: sign-magnitude leaves the top bit clear
   assert_sm_topbit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && sm_en) |=> !dac_word[WIDTH-1]);

   // R2: repeat of the same word never starts a mute
   assert_same_word_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_word == seen && !mute) |=> !mute);
endmodule

bind zc_deglitch zcd_checker #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .smp_word  (smp_word),
   .sm_en     (sm_en),
   .dac_word  (dac_word),
   .mute      (mute)
);

// File: tb/sim_zc_deglitch.sv
module sim_zc_deglitch;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam int LW = 8;
   localparam int CW = $clog2(W + 1);
   localparam int DEF_LEN = 8;

   typedef struct {
      logic [W-1:0] word;
      logic         neg;
      string        req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [W-1:0]  smp_word = '0;
   logic [LW-1:0] mute_len = '0;
   logic          cnt_en = 1'b0;
   logic [CW-1:0] cnt_limit = '0;
   logic          sm_en = 1'b0;
   logic [W-1:0]  dac_word;
   logic          dac_neg;
   logic          mute;

   int vectors = 0;
   int errors = 0;
   exp_t exp_q[$];
   logic [W-1:0] model_prev = 16'h8000;
   int  model_rem = 0;
   logic drv_flag = 1'b0;
   logic took = 1'b0;
   string mute_req = "R4";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zc_deglitch u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
      .mute_len(mute_len), .cnt_en(cnt_en), .cnt_limit(cnt_limit), .sm_en(sm_en),
      .dac_word(dac_word), .dac_neg(dac_neg), .mute(mute)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference model of the mute pulse, advanced at each rising edge
   always @(posedge clk) begin
      took <= smp_valid;
      if (rst_n) begin
         if (smp_valid && drv_flag) model_rem = (mute_len == 0) ? DEF_LEN : int'(mute_len);
         else if (model_rem > 0) model_rem = model_rem - 1;
      end
   end

   // Monitor: pop expected items and compare the mute every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(mute_req, {15'b0, mute}, {15'b0, model_rem != 0});
         if (took) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, dac_word, e.word);
            check(e.req, {15'b0, dac_neg}, {15'b0, e.neg});
         end
      end
   end

   // Driver: compute expected results and apply one sample
   task automatic apply(input logic [W-1:0] w, input string req);
      exp_t e;
      int s, m, ones;
      logic [W-1:0] tg;
      logic fl;
      tg = model_prev ^ w;
      ones = $countones(tg);
      fl = ((model_prev == 16'h7FFF) && (w == 16'h8000)) ||
           ((model_prev == 16'h8000) && (w == 16'h7FFF)) ||
           (cnt_en && ones > int'(cnt_limit));
      if (sm_en) begin
         s = int'(w) - 32768;
         m = (s < 0) ? -s : s;
         if (m > 32767) m = 32767;
         e.word = W'(m);
         e.neg = (s < 0);
      end else begin
         e.word = w;
         e.neg = 1'b0;
      end
      e.req = req;
      exp_q.push_back(e);
      @(negedge clk);
      smp_word = w;
      smp_valid = 1'b1;
      drv_flag = fl;
      @(negedge clk);
      smp_valid = 1'b0;
      drv_flag = 1'b0;
      model_prev = w;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic report;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      report();
   end

   initial begin
      idle(3);
      // R1: reset state
      check("R1", dac_word, 16'h8000);
      check("R1", {15'b0, dac_neg}, 16'h0);
      check("R1", {15'b0, mute}, 16'h0);
      rst_n = 1'b1;
      idle(2);
      // R3/R4: carry down from reset reference, default length
      apply(16'h7FFF, "R3");
      idle(12);
      apply(16'h8000, "R3");           // carry up
      idle(3);
      mute_req = "R5";
      apply(16'h7FFF, "R5");           // reload inside pulse
      idle(12);
      mute_req = "R6";
      apply(16'h0000, "R6");
      apply(16'hFFFF, "R6");           // full-scale, not a carry
      apply(16'h8001, "R6");
      apply(16'h7FFE, "R6");           // crosses zero but not the carry pair
      apply(16'h1234, "R2");
      idle(4);
      // R4: programmed length
      mute_len = 8'd3;
      mute_req = "R4";
      apply(16'h7FFF, "R4");
      apply(16'h8000, "R4");
      idle(6);
      // R7: count detector
      cnt_en = 1'b1;
      cnt_limit = CW'(4);
      mute_req = "R7";
      apply(16'h0000, "R7");
      idle(5);
      apply(16'h001F, "R7");           // five toggles, flagged
      idle(5);
      apply(16'h0000, "R7");           // five again
      idle(5);
      apply(16'h000F, "R7");           // four toggles, not flagged
      idle(5);
      cnt_en = 1'b0;
      mute_len = '0;
      // R8/R9: sign-magnitude
      sm_en = 1'b1;
      mute_req = "R8";
      apply(16'h0000, "R9");
      apply(16'h8000, "R8");
      apply(16'h7FFF, "R8");
      apply(16'hFFFF, "R8");
      apply(16'h8005, "R8");
      apply(16'h0001, "R8");
      idle(10);
      sm_en = 1'b0;
      apply(16'hA5A5, "R9");
      idle(10);
      done = 1'b1;
      report();
   end
endmodule